// File: doc/BRIEF.md
# Multi-Rate PHY Start-Up and Rate Sequencer

This block brings a multi-rate Ethernet physical layer up from reset. It decides which mode the transceiver's coding sublayer should run in and asks an external reconfiguration controller to switch to it. Each request is a one-cycle start strobe with a two-bit mode code. While the strobe is being issued and the controller is working, the block waits.

After reset it requests auto-negotiation mode. From there, two paths lead to a data mode:
- **Negotiated path.** A 10G result goes to link training and then to 10G data once training reports completion. A 1G result goes straight to 1G data.
- **Parallel detection.** If negotiation stays silent for `AN_WAIT` cycles, the block alternates the transceiver between 10G data and 1G data. Each attempt lasts a dwell time set on an input port. The search stops when a link comes up. If it does not, an overall `PD_TIMEOUT` sends the block back to auto-negotiation.

A link that was up and is then lost in a data mode restarts the whole sequence.

The FSM states are:

| State | Role |
|---|---|
| ISSUE | Waits for an idle controller, then strobes the pending mode. |
| RC_WAIT | Waits for the controller to finish the reconfiguration. |
| AN | Waits for negotiation to finish or for its timer to expire. |
| LT | Waits for training to finish. |
| PD_DWELL | One parallel-detection attempt. |
| DATA | Running; watches for link loss. |

The transitions are:
- ISSUE→RC_WAIT on strobe.
- RC_WAIT→AN, LT, PD_DWELL or DATA, chosen by the requested mode, once the controller is idle.
- AN→ISSUE on negotiation done or timer expiry.
- LT→ISSUE on training done.
- PD_DWELL→DATA on link up.
- PD_DWELL→ISSUE on timeout or dwell expiry.
- DATA→ISSUE on link loss.

Top module: `phy_mode_seq`

## Requirements
- R1: While reset is low, `seq_start_o` is 0 and `seq_mode_o` is 2'b00. The first strobe after reset requests auto-negotiation. Mode codes are 2'b00 auto-negotiation, 2'b01 link training, 2'b10 10G data, and 2'b11 1G data.
- R2: No strobe is issued in a cycle that follows a cycle with `rc_busy_i` high, and each strobe lasts exactly one cycle. The controller must raise busy in the cycle after a strobe.
- R3: Negotiation done with a 10G result leads to a link-training strobe. Training done then leads to a 10G data strobe.
- R4: Negotiation done with a 1G result leads directly to a 1G data strobe and never follows a training strobe.
- R5: If negotiation does not finish within `AN_WAIT` cycles, parallel detection starts with 10G data (default `PD_FIRST_10G`=1) and then alternates between 10G and 1G.
- R6: Each parallel-detection attempt lasts `pd_dwell_i` cycles plus a fixed overhead. Raising `pd_dwell_i` by N lengthens the gap between successive attempt strobes by exactly N.
- R7: `link_ok_i` high during an attempt locks that rate. No further strobe follows while the link stays up, even after `PD_TIMEOUT` has passed.
- R8: If no link is found, an auto-negotiation strobe follows `PD_TIMEOUT` cycles after parallel detection began. It may be late by at most one attempt's reconfiguration time.
- R9: In a data mode, a link that was up and then goes low causes an auto-negotiation strobe.
- R10: `seq_mode_o` changes only together with a strobe.
- R11: In a data mode entered through negotiation, `link_ok_i` low before the link has ever come up is ignored and causes no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_done_i | input | 1 | Auto-negotiation complete pulse |
| an_is_10g_i | input | 1 | Negotiated rate, 1 = 10G, 0 = 1G; valid with `an_done_i` |
| lt_done_i | input | 1 | Link training complete pulse |
| link_ok_i | input | 1 | Link status of the running data mode |
| rc_busy_i | input | 1 | Reconfiguration controller busy |
| pd_dwell_i | input | DWELL_W | Dwell cycles per parallel-detection attempt |
| seq_start_o | output | 1 | One-cycle reconfiguration request strobe |
| seq_mode_o | output | 2 | Requested mode code |

## Verification
The hardest situations to reach are the ends of parallel detection: a rate locked partway through the search, and the overall timeout. Both require negotiation to stay silent for the whole `AN_WAIT` window while a busy-reporting controller model answers every strobe. The bench therefore drives no completion pulses, lets the search run, and raises link status only right after a 1G attempt's reconfiguration finishes. It then holds the link past the overall timeout to show the lock is kept. The dwell length is measured differentially across two runs, so the check does not depend on the fixed reconfiguration overhead.

// File: rtl/phy_mode_seq_pkg.sv
package phy_mode_seq_pkg;

    typedef enum logic [1:0] {
        MODE_AN  = 2'b00,
        MODE_LT  = 2'b01,
        MODE_D10 = 2'b10,
        MODE_D1  = 2'b11
    } mode_t;

    typedef enum logic [2:0] {
        ST_ISSUE,
        ST_RC_WAIT,
        ST_AN,
        ST_LT,
        ST_PD_DWELL,
        ST_DATA
    } st_t;

endpackage

// File: rtl/mseq_timer.sv
module mseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mseq_link_mon.sv
module mseq_link_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic preset_up,
    input  logic arm,
    input  logic link_ok,
    output logic lost
);
    logic seen_up;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_up <= 1'b0;
        end else if (clear) begin
            seen_up <= preset_up;
        end else if (arm && link_ok) begin
            seen_up <= 1'b1;
        end
    end

    assign lost = arm && seen_up && !link_ok;
endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
    import phy_mode_seq_pkg::*;
#(
    parameter int AN_WAIT      = 64,
    parameter int PD_TIMEOUT   = 400,
    parameter int DWELL_W      = 10,
    parameter bit PD_FIRST_10G = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               an_done_i,
    input  logic               an_is_10g_i,
    input  logic               lt_done_i,
    input  logic               link_ok_i,
    input  logic               rc_busy_i,
    input  logic [DWELL_W-1:0] pd_dwell_i,
    output logic               seq_start_o,
    output logic [1:0]         seq_mode_o
);
    localparam int    AN_W     = $clog2(AN_WAIT + 1);
    localparam int    PH_W     = (AN_W > DWELL_W) ? AN_W : DWELL_W;
    localparam int    PD_W     = $clog2(PD_TIMEOUT + 1);
    localparam mode_t PD_FIRST = PD_FIRST_10G ? MODE_D10 : MODE_D1;

    st_t   state, state_nx;
    mode_t target, target_nx;
    logic  pd_active, pd_active_nx;

    logic            ph_load, ph_done, ph_run;
    logic [PH_W-1:0] ph_val;
    logic            pd_load, pd_tmr_done, pd_done;
    logic            mon_clear, mon_preset, mon_arm, link_lost;

    // Phase timer: negotiation wait and per-attempt dwell
    mseq_timer #(.W(PH_W)) ph_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .run      (ph_run),
        .done     (ph_done)
    );

    // Overall parallel-detection timeout
    mseq_timer #(.W(PD_W)) pd_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pd_load),
        .load_val (PD_W'(PD_TIMEOUT)),
        .run      (pd_active),
        .done     (pd_tmr_done)
    );

    mseq_link_mon link_mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (mon_clear),
        .preset_up (mon_preset),
        .arm       (mon_arm),
        .link_ok   (link_ok_i),
        .lost      (link_lost)
    );

    assign ph_run  = (state == ST_AN) || (state == ST_PD_DWELL);
    assign pd_done = pd_active && pd_tmr_done;
    assign mon_arm = (state == ST_DATA);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ISSUE;
            target    <= MODE_AN;
            pd_active <= 1'b0;
        end else begin
            state     <= state_nx;
            target    <= target_nx;
            pd_active <= pd_active_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx     = state;
        target_nx    = target;
        pd_active_nx = pd_active;
        ph_load      = 1'b0;
        ph_val       = PH_W'(AN_WAIT);
        pd_load      = 1'b0;
        mon_clear    = 1'b0;
        mon_preset   = 1'b0;
        unique case (state)
            ST_ISSUE: begin
                if (!rc_busy_i) state_nx = ST_RC_WAIT;
            end
            ST_RC_WAIT: begin
                if (!rc_busy_i && !seq_start_o) begin
                    unique case (target)
                        MODE_AN: begin
                            state_nx     = ST_AN;
                            pd_active_nx = 1'b0;
                            ph_load      = 1'b1;
                            ph_val       = PH_W'(AN_WAIT);
                        end
                        MODE_LT: state_nx = ST_LT;
                        MODE_D10, MODE_D1: begin
                            if (pd_active) begin
                                state_nx = ST_PD_DWELL;
                                ph_load  = 1'b1;
                                ph_val   = PH_W'(pd_dwell_i);
                            end else begin
                                state_nx   = ST_DATA;
                                mon_clear  = 1'b1;
                                mon_preset = 1'b0;
                            end
                        end
                        default: state_nx = ST_ISSUE;
                    endcase
                end
            end
            ST_AN: begin
                if (an_done_i) begin
                    target_nx = an_is_10g_i ? MODE_LT : MODE_D1;
                    state_nx  = ST_ISSUE;
                end else if (ph_done) begin
                    pd_active_nx = 1'b1;
                    pd_load      = 1'b1;
                    target_nx    = PD_FIRST;
                    state_nx     = ST_ISSUE;
                end
            end
            ST_LT: begin
                if (lt_done_i) begin
                    target_nx = MODE_D10;
                    state_nx  = ST_ISSUE;
                end
            end
            ST_PD_DWELL: begin
                if (link_ok_i) begin
                    state_nx     = ST_DATA;
                    pd_active_nx = 1'b0;
                    mon_clear    = 1'b1;
                    mon_preset   = 1'b1;
                end else if (pd_done) begin
                    target_nx = MODE_AN;
                    state_nx  = ST_ISSUE;
                end else if (ph_done) begin
                    target_nx = (target == MODE_D10) ? MODE_D1 : MODE_D10;
                    state_nx  = ST_ISSUE;
                end
            end
            ST_DATA: begin
                if (link_lost) begin
                    target_nx = MODE_AN;
                    state_nx  = ST_ISSUE;
                end
            end
            default: begin
                state_nx  = ST_ISSUE;
                target_nx = MODE_AN;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_start_o <= 1'b0;
            seq_mode_o  <= MODE_AN;
        end else begin
            seq_start_o <= 1'b0;
            if (state == ST_ISSUE && !rc_busy_i) begin
                seq_start_o <= 1'b1;
                seq_mode_o  <= target;
            end
        end
    end
endmodule

// File: rtl/phy_mode_seq_chk.sv
module phy_mode_seq_chk
    import phy_mode_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rc_busy_i,
    input logic       seq_start_o,
    input logic [1:0] seq_mode_o
);
    logic [1:0] last_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) last_mode <= MODE_AN;
        else if (seq_start_o) last_mode <= seq_mode_o;
    end

    // R2: strobe never follows a busy cycle
    a_r2_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |-> !$past(rc_busy_i));

    // R2: strobe is a single cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |=> !seq_start_o);

    // R10: mode only moves with a strobe
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_start_o |-> $stable(seq_mode_o));

    // R3: training is only requested after negotiation
    a_r3_lt_after_an: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start_o && seq_mode_o == MODE_LT) |-> last_mode == MODE_AN);

    // R4: 1G data never follows training
    a_r4_d1_not_after_lt: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start_o && seq_mode_o == MODE_D1) |-> last_mode != MODE_LT);
endmodule

bind phy_mode_seq phy_mode_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rc_busy_i   (rc_busy_i),
    .seq_start_o (seq_start_o),
    .seq_mode_o  (seq_mode_o)
);

// File: tb/phy_mode_seq_tb_top.sv
module phy_mode_seq_tb_top;
    localparam int AN_WAIT  = 64;
    localparam int PD_TO    = 400;
    localparam int DW       = 10;
    localparam int BUSY_LEN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          an_done = 1'b0, an_is_10g = 1'b0, lt_done = 1'b0, link_ok = 1'b0;
    logic          rc_busy = 1'b0;
    logic          hold_busy = 1'b0;
    logic [DW-1:0] dwell = 10'd40;
    logic          start;
    logic [1:0]    mode;
    int            bcnt = 0;
    int            cyc = 0;
    int            checks = 0, errors = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_mode_seq #(.AN_WAIT(AN_WAIT), .PD_TIMEOUT(PD_TO), .DWELL_W(DW), .PD_FIRST_10G(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .an_done_i(an_done), .an_is_10g_i(an_is_10g),
        .lt_done_i(lt_done), .link_ok_i(link_ok), .rc_busy_i(rc_busy),
        .pd_dwell_i(dwell), .seq_start_o(start), .seq_mode_o(mode));

    // Reconfiguration controller model: busy the cycle after a strobe
    always @(negedge clk) begin
        if (hold_busy) begin
            rc_busy <= 1'b1; bcnt <= 0;
        end else if (start) begin
            rc_busy <= 1'b1; bcnt <= BUSY_LEN;
        end else if (bcnt > 1) begin
            bcnt <= bcnt - 1;
        end else begin
            bcnt <= 0; rc_busy <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_strobe(input int maxc, output bit got, output logic [1:0] m, output int t);
        got = 1'b0; m = 2'b00; t = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (start) begin got = 1'b1; m = mode; t = cyc; return; end
        end
    endtask

    task automatic no_strobe(input int n, output bit quiet);
        quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (start) quiet = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (BUSY_LEN + 4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; link_ok = 1'b0; an_done = 1'b0; lt_done = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_an(input logic is10);
        @(negedge clk); an_done = 1'b1; an_is_10g = is10;
        @(negedge clk); an_done = 1'b0;
    endtask

    // R1 reset state and first request
    task automatic t_reset();
        bit g; logic [1:0] m; int t;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(start == 1'b0, "R1 start in reset", start, 0);
        chk(mode == 2'b00, "R1 mode in reset", mode, 0);
        rst_n = 1'b1;
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b00, "R1 first strobe auto-neg", m, 0);
    endtask

    // R2 busy holds off the strobe
    task automatic t_busy();
        bit g, q; logic [1:0] m; int t;
        @(negedge clk); rst_n = 1'b0; hold_busy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        no_strobe(30, q);
        chk(q, "R2 no strobe while busy", !q, 0);
        hold_busy = 1'b0;
        wait_strobe(6, g, m, t);
        chk(g && m == 2'b00, "R2 strobe after busy drops", g, 1);
    endtask

    // R3 and R9: negotiated 10G path then link loss
    task automatic t_path10();
        bit g, q; logic [1:0] m; int t;
        do_reset();
        wait_strobe(10, g, m, t);
        settle();
        pulse_an(1'b1);
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b01, "R3 training after 10G result", m, 1);
        settle();
        no_strobe(20, q);
        chk(q, "R3 waits for training", !q, 0);
        @(negedge clk); lt_done = 1'b1; @(negedge clk); lt_done = 1'b0;
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b10, "R3 10G data after training", m, 2);
        settle();
        link_ok = 1'b1;
        no_strobe(50, q);
        chk(q && mode == 2'b10, "R10 mode held in data", mode, 2);
        link_ok = 1'b0;
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b00, "R9 link loss restarts", m, 0);
    endtask

    // R4, R11, R9: negotiated 1G path
    task automatic t_path1();
        bit g, q; logic [1:0] m; int t;
        do_reset();
        wait_strobe(10, g, m, t);
        settle();
        pulse_an(1'b0);
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b11, "R4 1G data after 1G result", m, 3);
        settle();
        no_strobe(60, q);
        chk(q, "R11 link never up is ignored", !q, 0);
        chk(mode == 2'b11, "R11 mode stays 1G", mode, 3);
        link_ok = 1'b1;
        repeat (20) @(negedge clk);
        link_ok = 1'b0;
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b00, "R9 1G link loss restarts", m, 0);
    endtask

    // R5 first attempts; returns gap between first two attempt strobes
    task automatic pd_gap(input logic [DW-1:0] dw, output int gap);
        bit g; logic [1:0] m; int t1, t2, t3;
        dwell = dw;
        do_reset();
        wait_strobe(10, g, m, t1);
        wait_strobe(AN_WAIT + 40, g, m, t1);
        chk(g && m == 2'b10, "R5 first attempt 10G", m, 2);
        wait_strobe(dw + 40, g, m, t2);
        chk(g && m == 2'b11, "R5 second attempt 1G", m, 3);
        wait_strobe(dw + 40, g, m, t3);
        chk(g && m == 2'b10, "R5 third attempt 10G", m, 2);
        gap = t2 - t1;
    endtask

    task automatic t_dwell();
        int g1, g2;
        pd_gap(10'd30, g1);
        pd_gap(10'd60, g2);
        chk(g2 - g1 == 30, "R6 dwell adds one-for-one", g2 - g1, 30);
    endtask

    // R8 timeout back to auto-neg
    task automatic t_timeout();
        bit g; logic [1:0] m, prev; int t0, t, n;
        dwell = 10'd40;
        do_reset();
        wait_strobe(10, g, m, t);
        wait_strobe(AN_WAIT + 40, g, m, t0);
        prev = m; n = 1;
        for (int i = 0; i < 20; i++) begin
            wait_strobe(200, g, m, t);
            if (!g || m == 2'b00) break;
            chk(m != prev, "R5 attempts alternate", m, ~prev);
            prev = m; n++;
        end
        chk(g && m == 2'b00, "R8 timeout requests auto-neg", m, 0);
        chk(n >= 3, "R8 several attempts before timeout", n, 3);
        chk((t - t0) >= PD_TO - 5 && (t - t0) <= PD_TO + 20, "R8 timeout length", t - t0, PD_TO);
    endtask

    // R7 lock on link during an attempt
    task automatic t_lock();
        bit g, q; logic [1:0] m; int t;
        dwell = 10'd40;
        do_reset();
        wait_strobe(10, g, m, t);
        wait_strobe(AN_WAIT + 40, g, m, t);
        wait_strobe(100, g, m, t);
        chk(g && m == 2'b11, "R7 reach 1G attempt", m, 3);
        settle();
        link_ok = 1'b1;
        no_strobe(PD_TO + 100, q);
        chk(q && mode == 2'b11, "R7 lock held past timeout", mode, 3);
        link_ok = 1'b0;
        wait_strobe(10, g, m, t);
        chk(g && m == 2'b00, "R9 loss after lock restarts", m, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_busy();
        t_path10();
        t_path1();
        t_dwell();
        t_timeout();
        t_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule